// File: doc/BRIEF.md
# Saturating Q31 Fractional Multiplier

This block is a pipelined signed 32x32 multiplier with three result modes. Full mode returns the whole 64-bit two's complement product as a high word and a low word. High-word mode returns only the upper 32 bits of the raw product. In that result the sign bit appears twice and one bit of precision is lost. Fractional mode treats both operands as Q31 values and returns a Q31 product. It shifts the high word up by one place, refills the freed bit from the top bit of the low word, and clamps the single overflow case so that it cannot wrap.

A new operation can be issued on any cycle with a valid strobe, two operands and a mode code, and there is no back-pressure. Each operation carries its mode tag down a three-stage pipeline. Full and high-word results normally leave after one cycle and fractional results after three. A short operation that would overtake an older fractional one is held back, so results always come out in issue order and none is dropped.

Top module: `q31_mul_unit`

## Requirements
- R1: Full mode (mode code 2'b00) gives res_hi = product[63:32] and res_lo = product[31:0], where product is the signed 64-bit product of op_a and op_b. sat_flag stays 0. When no older operation is undelivered, the result is valid in the cycle right after the operands are sampled.
- R2: High-word mode (mode code 2'b01) gives res_hi = product[63:32] and res_lo = 0. Its latency follows the rule in R1.
- R3: Fractional mode (mode code 2'b10) gives res_hi = product[62:31] and res_lo = 0. The result truncates toward negative infinity, and low-word bits 30:0 are dropped. The result is valid exactly three cycles after the operands are sampled.
- R4: In fractional mode, op_a = op_b = 0x80000000 gives res_hi = 0x7FFFFFFF with sat_flag = 1, both in the same cycle as out_valid.
- R5: sat_flag is 1 only alongside out_valid for a fractional operation whose clamp fired. It is 0 for every other operand pair and in every other mode, including full and high-word products of 0x80000000 by itself.
- R6: Mode code 2'b11 behaves exactly like full mode.
- R7: Results are delivered in issue order, at most one per cycle. Each result appears in the earliest cycle that meets both of these conditions: its own latency (one cycle for full or high-word, three for fractional) has elapsed, and every older result has already been delivered in an earlier cycle.
- R8: An operation is accepted on every cycle that in_valid is high, including long back-to-back runs of mixed modes, and none is lost.
- R9: While rst_n is low, and afterwards until a new operation completes, out_valid and sat_flag are 0. Operations in flight when reset is asserted are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Issues an operation this cycle |
| op_a | input | 32 | First operand, two's complement |
| op_b | input | 32 | Second operand, two's complement |
| mode | input | 2 | Result mode: 00 full, 01 high word, 10 fractional, 11 full |
| out_valid | output | 1 | A result is presented this cycle |
| res_hi | output | 32 | Upper result word, or the Q31 result |
| res_lo | output | 32 | Lower product word in full mode, otherwise 0 |
| sat_flag | output | 1 | The fractional clamp fired for this result |

## Verification
The key collision is between a fractional result reaching the end of the pipeline and a younger full or high-word operation that has reached its own one-cycle latency at the same moment. Both would claim the single output port in that cycle. The bench provokes this by issuing a fractional operation followed, one or two cycles later, by short-mode operations, and also by random back-to-back streams of mixed modes. For every operation it predicts the delivery cycle as the later of its own latency and one cycle after the previous result. It then requires that exact cycle, that exact order and the exact result words, and it treats any result that was not predicted as a failure.

// File: rtl/q31_mul_pkg.sv
package q31_mul_pkg;

  // Result mode codes; the encoding is visible at the mode port.
  typedef enum logic [1:0] {
    MODE_FULL = 2'b00,
    MODE_HIGH = 2'b01,
    MODE_FRAC = 2'b10,
    MODE_ALTF = 2'b11
  } mul_mode_e;

  // Number of pipeline slots; the fractional path needs all of them.
  localparam int unsigned NUM_STG = 3;

endpackage

// File: rtl/q31_signed_mult.sv
module q31_signed_mult #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned PROD_W = 2 * DATA_W
) (
  input  logic [DATA_W-1:0] mul_a,
  input  logic [DATA_W-1:0] mul_b,
  output logic [PROD_W-1:0] mul_p
);

  logic signed [PROD_W-1:0] ext_a;
  logic signed [PROD_W-1:0] ext_b;
  logic signed [PROD_W-1:0] full_p;

  always_comb begin
    ext_a  = {{DATA_W{mul_a[DATA_W-1]}}, mul_a};
    ext_b  = {{DATA_W{mul_b[DATA_W-1]}}, mul_b};
    full_p = ext_a * ext_b;
    mul_p  = full_p;
  end

endmodule

// File: rtl/q31_sat_double.sv
module q31_sat_double #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] dbl_in,
  output logic [DATA_W-1:0] dbl_out,
  output logic              dbl_ovf
);

  localparam logic [DATA_W-1:0] POS_LIM = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_LIM = {1'b1, {(DATA_W-1){1'b0}}};

  always_comb begin
    // Doubling overflows when the two top bits differ.
    dbl_ovf = dbl_in[DATA_W-1] ^ dbl_in[DATA_W-2];
    if (dbl_ovf) begin
      dbl_out = dbl_in[DATA_W-1] ? NEG_LIM : POS_LIM;
    end else begin
      dbl_out = {dbl_in[DATA_W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/q31_sat_inc.sv
module q31_sat_inc #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] inc_in,
  input  logic              inc_bit,
  output logic [DATA_W-1:0] inc_out,
  output logic              inc_ovf
);

  localparam logic [DATA_W-1:0] POS_LIM = {1'b0, {(DATA_W-1){1'b1}}};

  logic [DATA_W-1:0] raw_sum;

  always_comb begin
    raw_sum = inc_in + {{(DATA_W-1){1'b0}}, inc_bit};
    inc_ovf = inc_bit && (inc_in == POS_LIM);
    inc_out = inc_ovf ? POS_LIM : raw_sum;
  end

endmodule

// File: rtl/q31_result_fmt.sv
module q31_result_fmt
  import q31_mul_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned PROD_W = 2 * DATA_W
) (
  input  logic              fmt_vld,
  input  mul_mode_e         fmt_mode,
  input  logic [PROD_W-1:0] fmt_prod,
  input  logic [DATA_W-1:0] fmt_frac,
  input  logic              fmt_sat,
  output logic [DATA_W-1:0] fmt_hi,
  output logic [DATA_W-1:0] fmt_lo,
  output logic              fmt_satf
);

  always_comb begin
    fmt_hi   = '0;
    fmt_lo   = '0;
    fmt_satf = 1'b0;
    if (fmt_vld) begin
      unique case (fmt_mode)
        MODE_HIGH: begin
          fmt_hi = fmt_prod[PROD_W-1:DATA_W];
        end
        MODE_FRAC: begin
          fmt_hi   = fmt_frac;
          fmt_satf = fmt_sat;
        end
        default: begin
          fmt_hi = fmt_prod[PROD_W-1:DATA_W];
          fmt_lo = fmt_prod[DATA_W-1:0];
        end
      endcase
    end
  end

endmodule

// File: rtl/q31_mul_unit.sv
module q31_mul_unit
  import q31_mul_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [1:0]        mode,
  output logic              out_valid,
  output logic [DATA_W-1:0] res_hi,
  output logic [DATA_W-1:0] res_lo,
  output logic              sat_flag
);

  localparam int unsigned PROD_W = 2 * DATA_W;
  localparam int unsigned LAST   = NUM_STG;

  typedef struct packed {
    mul_mode_e         mode;
    logic [PROD_W-1:0] prod;
    logic [DATA_W-1:0] frac;
    logic              sat;
  } slot_t;

  logic [LAST:1] stg_vld;
  logic [LAST:1] vld_d;
  logic [LAST:1] take;
  slot_t         pay_q [1:LAST];
  slot_t         pay_d [1:LAST];

  logic [PROD_W-1:0] new_prod;
  logic [DATA_W-1:0] dbl_val;
  logic              dbl_ovf;
  logic [DATA_W-1:0] inc_val;
  logic              inc_ovf;
  slot_t             out_slot;
  logic              out_any;

  q31_signed_mult #(.DATA_W(DATA_W)) u_mult (
    .mul_a (op_a),
    .mul_b (op_b),
    .mul_p (new_prod)
  );

  q31_sat_double #(.DATA_W(DATA_W)) u_dbl (
    .dbl_in  (pay_q[1].prod[PROD_W-1:DATA_W]),
    .dbl_out (dbl_val),
    .dbl_ovf (dbl_ovf)
  );

  q31_sat_inc #(.DATA_W(DATA_W)) u_inc (
    .inc_in  (pay_q[2].frac),
    .inc_bit (pay_q[2].prod[DATA_W-1]),
    .inc_out (inc_val),
    .inc_ovf (inc_ovf)
  );

  // Output selection: oldest slot first; a short op leaves early only
  // when nothing older is still waiting further down the pipe.
  always_comb begin
    take       = '0;
    take[LAST] = stg_vld[LAST];
    take[2]    = !stg_vld[LAST] && stg_vld[2] && (pay_q[2].mode != MODE_FRAC);
    take[1]    = !stg_vld[LAST] && !stg_vld[2] && stg_vld[1]
                 && (pay_q[1].mode != MODE_FRAC);
  end

  // Next-state for every slot.
  always_comb begin
    vld_d[1]      = in_valid;
    pay_d[1].mode = mul_mode_e'(mode);
    pay_d[1].prod = new_prod;
    pay_d[1].frac = '0;
    pay_d[1].sat  = 1'b0;

    vld_d[2]      = stg_vld[1] && !take[1];
    pay_d[2]      = pay_q[1];
    pay_d[2].frac = dbl_val;
    pay_d[2].sat  = dbl_ovf;

    vld_d[LAST]      = stg_vld[2] && !take[2];
    pay_d[LAST]      = pay_q[2];
    pay_d[LAST].frac = inc_val;
    pay_d[LAST].sat  = pay_q[2].sat || inc_ovf;
  end

  // Slot registers: valid bits reset, payload loaded only with a live op.
  for (genvar g = 1; g <= LAST; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_vld[g] <= 1'b0;
      end else begin
        stg_vld[g] <= vld_d[g];
      end
    end

    always_ff @(posedge clk) begin
      if (vld_d[g]) begin
        pay_q[g] <= pay_d[g];
      end
    end
  end

  always_comb begin
    out_any = |take;
    if (take[LAST]) begin
      out_slot = pay_q[LAST];
    end else if (take[2]) begin
      out_slot = pay_q[2];
    end else begin
      out_slot = pay_q[1];
    end
  end

  q31_result_fmt #(.DATA_W(DATA_W)) u_fmt (
    .fmt_vld  (out_any),
    .fmt_mode (out_slot.mode),
    .fmt_prod (out_slot.prod),
    .fmt_frac (out_slot.frac),
    .fmt_sat  (out_slot.sat),
    .fmt_hi   (res_hi),
    .fmt_lo   (res_lo),
    .fmt_satf (sat_flag)
  );

  assign out_valid = out_any;

endmodule

// File: rtl/q31_mul_chk.sv
module q31_mul_chk
  import q31_mul_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic [1:0]        mode,
  input logic              out_valid,
  input logic [DATA_W-1:0] res_hi,
  input logic              sat_flag,
  input logic              s1_vld,
  input logic              s2_vld
);

  localparam logic [DATA_W-1:0] POS_LIM = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_LIM = {1'b1, {(DATA_W-1){1'b0}}};

  logic [3:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_q + {3'd0, in_valid} - {3'd0, out_valid};
    end
  end

  // R9: quiet while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r9_reset_quiet: assert (!out_valid && !sat_flag);
    end
  end

  // R4
  a_r4_clamp_value: assert property (@(posedge clk) disable iff (!rst_n)
    sat_flag |-> (res_hi == POS_LIM));

  // R4
  a_r4_minmin_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == MODE_FRAC && op_a == NEG_LIM && op_b == NEG_LIM)
    |-> ##3 (out_valid && sat_flag));

  // R5
  a_r5_flag_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    sat_flag |-> out_valid);

  // R5
  a_r5_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    sat_flag |-> ($past(in_valid, 3) && $past(mode, 3) == MODE_FRAC
                  && $past(op_a, 3) == NEG_LIM && $past(op_b, 3) == NEG_LIM));

  // R3
  a_r3_frac_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == MODE_FRAC) |-> ##3 out_valid);

  // R1
  a_r1_short_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode != MODE_FRAC && !s1_vld && !s2_vld) |=> out_valid);

  // R7
  a_r7_pend_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= 4'd3);

  // R7
  a_r7_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (pend_q != 4'd0));

endmodule

bind q31_mul_unit q31_mul_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_a      (op_a),
  .op_b      (op_b),
  .mode      (mode),
  .out_valid (out_valid),
  .res_hi    (res_hi),
  .sat_flag  (sat_flag),
  .s1_vld    (stg_vld[1]),
  .s2_vld    (stg_vld[2])
);

// File: tb/q31_mul_unit_tb_top.sv
module q31_mul_unit_tb_top;

  localparam logic [31:0] NEG_LIM = 32'h8000_0000;
  localparam logic [31:0] POS_LIM = 32'h7FFF_FFFF;
  localparam int QD = 512;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] op_a;
  logic [31:0] op_b;
  logic [1:0]  mode;
  logic        out_valid;
  logic [31:0] res_hi;
  logic [31:0] res_lo;
  logic        sat_flag;

  q31_mul_unit dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .mode      (mode),
    .out_valid (out_valid),
    .res_hi    (res_hi),
    .res_lo    (res_lo),
    .sat_flag  (sat_flag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk  = 0;
  int n_fail = 0;
  bit mon_en = 1'b0;

  logic [31:0] q_hi  [QD];
  logic [31:0] q_lo  [QD];
  logic        q_sat [QD];
  int          q_cyc [QD];
  string       q_tag [QD];
  int q_head = 0;
  int q_tail = 0;
  int last_exp = 0;

  function automatic void ref_model(input logic [31:0] a, input logic [31:0] b,
                                    input logic [1:0] m, output logic [31:0] hi,
                                    output logic [31:0] lo, output logic sat);
    longint      p;
    logic [63:0] pu;
    p   = longint'($signed(a)) * longint'($signed(b));
    pu  = p;
    sat = 1'b0;
    lo  = '0;
    case (m)
      2'b01: hi = pu[63:32];
      2'b10: begin
        if (a == NEG_LIM && b == NEG_LIM) begin
          hi  = POS_LIM;
          sat = 1'b1;
        end else begin
          hi = pu[62:31];
        end
      end
      default: begin
        hi = pu[63:32];
        lo = pu[31:0];
      end
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // Output monitor: every predicted result must appear in its exact cycle.
  always @(negedge clk) begin
    if (mon_en) begin
      if (q_head != q_tail && cyc == q_cyc[q_head % QD]) begin
        check(out_valid == 1'b1, q_tag[q_head % QD], "out_valid", {63'd0, out_valid}, 64'd1);
        if (out_valid) begin
          check({res_hi, res_lo} == {q_hi[q_head % QD], q_lo[q_head % QD]},
                q_tag[q_head % QD], "result", {res_hi, res_lo},
                {q_hi[q_head % QD], q_lo[q_head % QD]});
          check(sat_flag == q_sat[q_head % QD], q_tag[q_head % QD], "sat_flag",
                {63'd0, sat_flag}, {63'd0, q_sat[q_head % QD]});
        end
        q_head++;
      end else if (out_valid) begin
        check(1'b0, "R7", "unexpected result", {res_hi, res_lo}, 64'd0);
      end
    end
  end

  task automatic issue(input logic [31:0] a, input logic [31:0] b,
                       input logic [1:0] m, input string tag);
    logic [31:0] hi;
    logic [31:0] lo;
    logic        sat;
    int          k;
    int          e;
    @(negedge clk);
    in_valid = 1'b1;
    op_a     = a;
    op_b     = b;
    mode     = m;
    ref_model(a, b, m, hi, lo, sat);
    k = cyc + 1;
    e = (m == 2'b10) ? k + 2 : k;
    if (e <= last_exp) e = last_exp + 1;
    last_exp = e;
    q_hi[q_tail % QD]  = hi;
    q_lo[q_tail % QD]  = lo;
    q_sat[q_tail % QD] = sat;
    q_cyc[q_tail % QD] = e;
    q_tag[q_tail % QD] = tag;
    q_tail++;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic drain();
    idle(1);
    while (q_head != q_tail) idle(1);
    idle(2);
  endtask

  task automatic do_reset();
    mon_en   = 1'b0;
    in_valid = 1'b0;
    rst_n    = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n    = 1'b1;
    q_head   = 0;
    q_tail   = 0;
    last_exp = cyc;
    mon_en   = 1'b1;
  endtask

  task automatic t_reset_state();
    idle(1);
    check(!out_valid && !sat_flag, "R9", "idle after reset",
          {62'd0, out_valid, sat_flag}, 64'd0);
  endtask

  task automatic t_full_mode();
    issue(32'h0000_0003, 32'h0000_0005, 2'b00, "R1");
    idle(2);
    issue(NEG_LIM, NEG_LIM, 2'b00, "R1");
    idle(1);
    issue(POS_LIM, POS_LIM, 2'b00, "R1");
    issue(NEG_LIM, POS_LIM, 2'b00, "R1");
    issue(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b00, "R1");
    issue(32'h0000_0000, 32'h1234_5678, 2'b00, "R1");
    issue(32'hDEAD_BEEF, 32'h0BAD_F00D, 2'b00, "R1");
    drain();
  endtask

  task automatic t_high_mode();
    issue(NEG_LIM, NEG_LIM, 2'b01, "R2");
    idle(1);
    issue(POS_LIM, 32'h4000_0000, 2'b01, "R2");
    issue(32'hFFFF_FFFF, 32'h0000_0001, 2'b01, "R2");
    issue(32'h8765_4321, 32'h1357_9BDF, 2'b01, "R2");
    drain();
  endtask

  task automatic t_frac_mode();
    issue(32'h4000_0000, 32'h4000_0000, 2'b10, "R3");
    idle(4);
    issue(32'hFFFF_FFFF, 32'h0000_0001, 2'b10, "R3");
    issue(POS_LIM, POS_LIM, 2'b10, "R3");
    issue(NEG_LIM, POS_LIM, 2'b10, "R3");
    issue(32'h0000_0000, NEG_LIM, 2'b10, "R3");
    issue(32'hC000_0000, 32'h6000_0001, 2'b10, "R3");
    drain();
  endtask

  task automatic t_saturate();
    issue(NEG_LIM, NEG_LIM, 2'b10, "R4");
    idle(4);
    issue(NEG_LIM, NEG_LIM, 2'b00, "R5");
    issue(NEG_LIM, NEG_LIM, 2'b01, "R5");
    issue(NEG_LIM, 32'h8000_0001, 2'b10, "R5");
    issue(NEG_LIM, NEG_LIM, 2'b10, "R4");
    issue(NEG_LIM, NEG_LIM, 2'b11, "R5");
    drain();
  endtask

  task automatic t_alt_full();
    issue(32'h8000_0001, 32'h7FFF_FFFE, 2'b11, "R6");
    idle(1);
    issue(32'h0001_0000, 32'hFFFF_0000, 2'b11, "R6");
    drain();
  endtask

  task automatic t_collision();
    // short op lands at its own latency in the cycle the fractional result exits
    issue(32'h2000_0000, 32'h3000_0000, 2'b10, "R7");
    idle(1);
    issue(32'h0000_0007, 32'hFFFF_FFF9, 2'b01, "R7");
    issue(32'h1111_1111, 32'h2222_2222, 2'b00, "R7");
    drain();
    issue(32'h5555_5555, 32'hAAAA_AAAB, 2'b10, "R7");
    issue(32'h0000_0010, 32'h0000_0020, 2'b00, "R7");
    issue(32'h7000_0000, 32'h7000_0000, 2'b10, "R7");
    issue(32'hFFFF_FFFE, 32'h0000_0003, 2'b01, "R7");
    drain();
  endtask

  task automatic t_stream();
    for (int i = 0; i < 120; i++) begin
      logic [31:0] a;
      logic [31:0] b;
      logic [1:0]  m;
      a = $urandom;
      b = $urandom;
      m = 2'($urandom);
      if (i % 17 == 0) a = NEG_LIM;
      if (i % 23 == 0) b = NEG_LIM;
      if (i % 13 == 0) a = POS_LIM;
      if (i % 11 == 0) b = 32'h0;
      issue(a, b, m, "R8");
    end
    drain();
  endtask

  task automatic t_reset_flush();
    issue(NEG_LIM, NEG_LIM, 2'b10, "R9");
    @(negedge clk);
    in_valid = 1'b0;
    mon_en   = 1'b0;
    rst_n    = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!out_valid && !sat_flag, "R9", "output during reset",
            {62'd0, out_valid, sat_flag}, 64'd0);
    end
    rst_n    = 1'b1;
    q_head   = 0;
    q_tail   = 0;
    last_exp = cyc;
    mon_en   = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!out_valid && !sat_flag, "R9", "output after reset",
            {62'd0, out_valid, sat_flag}, 64'd0);
    end
    issue(32'h0000_0002, 32'h0000_0003, 2'b00, "R9");
    drain();
  endtask

  initial begin
    in_valid = 1'b0;
    op_a     = '0;
    op_b     = '0;
    mode     = 2'b00;
    rst_n    = 1'b0;
    fork
      begin
        do_reset();
        t_reset_state();
        t_full_mode();
        t_high_mode();
        t_frac_mode();
        t_saturate();
        t_alt_full();
        t_collision();
        t_stream();
        t_reset_flush();
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule